// File: doc/BRIEF.md
# HUB Floating-Point Adder

This block adds or subtracts two floating-point numbers held in half-unit-biased (HUB) form, through a five-stage pipeline that accepts a new operation on every clock. A HUB number keeps the usual sign bit and biased exponent field. Its stored fraction is read with an implicit 1 in front and an implicit 1 behind the last stored bit, so the effective significand always lies strictly between 1 and 2. Because that trailing 1 already carries half a unit of bias, cutting the exact result down to the stored width gives nearest rounding. The block therefore has no guard, round or sticky bits and no rounding stage.

The stages, in order, are: compare exponents and swap the operands; align the smaller one and negate it for subtraction; add and correct a carry-out; count leading zeros; normalize and register the result. The format width comes from two parameters. The default is a 32-bit word with an 8-bit exponent (bias 127) and a 23-bit fraction. Zero, infinity, a quiet NaN, underflow and overflow are handled in simple, fixed ways. Subnormals, other rounding modes and status flags are not supported.

Top module: `hub_fp_add`

## Requirements
- R1: An operand word is {sign[W-1], exponent[W-2:FRAC_W], fraction[FRAC_W-1:0]}. An exponent field between 1 and all-ones minus 1 encodes 2^(e-127) times 1.fraction with a 1 appended after the fraction. For example, 0x3F800000 + 0x3F800000 returns 0x40000000.
- R2: A result appears on out_res with out_valid high exactly 5 clock cycles after the cycle in which in_valid was sampled high. Operations issued on consecutive cycles produce results on consecutive cycles, in issue order.
- R3: out_valid is high only for operations that were accepted. A cycle with in_valid low produces no result.
- R4: When in_sub is 1, the sign of in_b is inverted before the operation. The result takes the sign of the operand with the larger magnitude. Example: 0x3F800000 - 0x40000000 returns 0xBF800001.
- R5: Bits of the smaller significand that are shifted out during alignment are discarded. The normalized result is truncated to FRAC_W bits with no rounding increment.
- R6: When the exponent difference is at least FRAC_W+2, the result is the larger operand with its adjusted sign. Example: 0x3F800000 - 0x4C000000 returns 0xCC000000.
- R7: Subtracting equal finite magnitudes gives +0 (0x00000000), whatever the operand signs.
- R8: An operand with exponent field 0 is zero, whatever its fraction. A zero plus a finite operand returns that operand with its adjusted sign. Two zeros give a zero that is negative only if both adjusted signs are negative.
- R9: When the result exponent would fall below 1, the result is flushed to a zero that keeps the result sign. The block never outputs a zero exponent with a nonzero fraction.
- R10: When the result exponent would reach all-ones, the result saturates to infinity with the result sign (0x7F800000 or 0xFF800000).
- R11: An infinite operand passes through with its adjusted sign. Infinities of opposite effective sign, or any NaN operand (exponent all-ones with a nonzero fraction), give the quiet NaN 0x7FC00000.
- R12: While rst_n is low, out_valid is 0 and any operation presented is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| in_sub | input | 1 | 1 selects a - b, 0 selects a + b |
| in_a | input | 1+EXP_W+FRAC_W | First operand, HUB format |
| in_b | input | 1+EXP_W+FRAC_W | Second operand, HUB format |
| out_valid | output | 1 | Result strobe |
| out_res | output | 1+EXP_W+FRAC_W | Result, HUB format |

## Verification
Directed operands exercise each path separately. Equal exponents with a carry-out exercise the right-shift correction. A one-step exponent gap under subtraction shows that aligned bits are dropped and the sign comes from the larger operand. A gap of 25 shows the smaller operand vanishing completely. Exact cancellation, exponent-1 differences, maximum-exponent sums, zeros and infinities each drive one of the fixed-outcome paths. Random operands with nearby exponents mix add and subtract and stress leading-zero counts of every size. These run back to back and with gaps, which confirms both throughput and the absence of spurious results.

// File: rtl/hub_fp_add.sv
module hub_fp_add #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic                        in_sub,
  input  logic [EXP_W+FRAC_W:0]       in_a,
  input  logic [EXP_W+FRAC_W:0]       in_b,
  output logic                        out_valid,
  output logic [EXP_W+FRAC_W:0]       out_res
);
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int SIG_W = FRAC_W + 2;
  localparam int SH_W  = $clog2(SIG_W + 1);
  localparam int LZ_W  = $clog2(SIG_W);
  localparam int XE_W  = EXP_W + 2;
  localparam logic [EXP_W-1:0] EMAX = '1;
  localparam logic [W-1:0] QNAN = {1'b0, EMAX, 1'b1, {(FRAC_W-1){1'b0}}};

  // stage 1: decode, exponent difference, swap
  logic              sa, sb;
  logic [EXP_W-1:0]  ea, eb;
  logic [FRAC_W-1:0] fa, fb;
  assign sa = in_a[W-1];
  assign sb = in_b[W-1] ^ in_sub;
  assign ea = in_a[W-2 -: EXP_W];
  assign eb = in_b[W-2 -: EXP_W];
  assign fa = in_a[FRAC_W-1:0];
  assign fb = in_b[FRAC_W-1:0];

  logic a_zero, b_zero, a_inf, b_inf, a_nan, b_nan, swap;
  assign a_zero = (ea == '0);
  assign b_zero = (eb == '0);
  assign a_inf  = (ea == EMAX) && (fa == '0);
  assign b_inf  = (eb == EMAX) && (fb == '0);
  assign a_nan  = (ea == EMAX) && (fa != '0);
  assign b_nan  = (eb == EMAX) && (fb != '0);
  assign swap   = {eb, fb} > {ea, fa};

  logic [EXP_W-1:0]  big_e, sml_e, ediff;
  logic [FRAC_W-1:0] big_f, sml_f;
  assign big_e = swap ? eb : ea;
  assign sml_e = swap ? ea : eb;
  assign big_f = swap ? fb : fa;
  assign sml_f = swap ? fa : fb;
  assign ediff = big_e - sml_e;

  logic           sp_hit;
  logic [W-1:0]   sp_val;
  always_comb begin
    sp_hit = 1'b1;
    sp_val = '0;
    if (a_nan || b_nan || (a_inf && b_inf && (sa != sb))) sp_val = QNAN;
    else if (a_inf)               sp_val = {sa, EMAX, {FRAC_W{1'b0}}};
    else if (b_inf)               sp_val = {sb, EMAX, {FRAC_W{1'b0}}};
    else if (a_zero && b_zero)    sp_val = {sa & sb, {(W-1){1'b0}}};
    else if (b_zero)              sp_val = {sa, ea, fa};
    else if (a_zero)              sp_val = {sb, eb, fb};
    else                          sp_hit = 1'b0;
  end

  logic              v1, sp1, sg1, sub1;
  logic [W-1:0]      spv1;
  logic [EXP_W-1:0]  e1;
  logic [SIG_W-1:0]  big1, sml1;
  logic [SH_W-1:0]   sh1;
  always_ff @(posedge clk) begin
    if (!rst_n) v1 <= 1'b0;
    else        v1 <= in_valid;
    sp1  <= sp_hit;
    spv1 <= sp_val;
    sg1  <= swap ? sb : sa;
    sub1 <= sa ^ sb;
    e1   <= big_e;
    big1 <= {1'b1, big_f, 1'b1};
    sml1 <= {1'b1, sml_f, 1'b1};
    sh1  <= (ediff >= EXP_W'(SIG_W)) ? SH_W'(SIG_W) : SH_W'(ediff);
  end

  // stage 2: alignment, two's complement for subtraction
  logic [SIG_W-1:0] aligned;
  assign aligned = sml1 >> sh1;

  logic              v2, sp2, sg2, sub2;
  logic [W-1:0]      spv2;
  logic [EXP_W-1:0]  e2;
  logic [SIG_W-1:0]  big2;
  logic [SIG_W:0]    op2;
  always_ff @(posedge clk) begin
    if (!rst_n) v2 <= 1'b0;
    else        v2 <= v1;
    sp2  <= sp1;
    spv2 <= spv1;
    sg2  <= sg1;
    sub2 <= sub1;
    e2   <= e1;
    big2 <= big1;
    op2  <= ({1'b0, aligned} ^ {(SIG_W+1){sub1}}) + (SIG_W+1)'(sub1);
  end

  // stage 3: add/subtract, carry-out correction
  logic [SIG_W:0] sum;
  logic           carry;
  assign sum   = {1'b0, big2} + op2;
  assign carry = ~sub2 & sum[SIG_W];

  logic              v3, sp3, sg3;
  logic [W-1:0]      spv3;
  logic [XE_W-1:0]   e3;
  logic [SIG_W-1:0]  sig3;
  always_ff @(posedge clk) begin
    if (!rst_n) v3 <= 1'b0;
    else        v3 <= v2;
    sp3  <= sp2;
    spv3 <= spv2;
    sg3  <= sg2;
    e3   <= {2'b00, e2} + XE_W'(carry);
    sig3 <= carry ? sum[SIG_W:1] : sum[SIG_W-1:0];
  end

  // stage 4: leading-zero detection
  logic [LZ_W-1:0] lz;
  always_comb begin
    lz = '0;
    for (int i = 0; i < SIG_W; i++)
      if (sig3[i]) lz = LZ_W'(SIG_W - 1 - i);
  end

  logic              v4, sp4, sg4, z4;
  logic [W-1:0]      spv4;
  logic [XE_W-1:0]   e4;
  logic [SIG_W-1:0]  sig4;
  logic [LZ_W-1:0]   lz4;
  always_ff @(posedge clk) begin
    if (!rst_n) v4 <= 1'b0;
    else        v4 <= v3;
    sp4  <= sp3;
    spv4 <= spv3;
    sg4  <= sg3;
    z4   <= (sig3 == '0);
    e4   <= e3;
    sig4 <= sig3;
    lz4  <= lz;
  end

  // stage 5: normalization shift, truncation, range limits
  logic signed [XE_W-1:0] en;
  logic [FRAC_W-1:0]      frac;
  logic [W-1:0]           res;
  assign en   = $signed(e4) - $signed(XE_W'(lz4));
  assign frac = FRAC_W'((sig4 << lz4) >> 1);

  always_comb begin
    if (sp4)                                    res = spv4;
    else if (z4)                                res = '0;
    else if (en < $signed(XE_W'(1)))            res = {sg4, {(W-1){1'b0}}};
    else if (en >= $signed({2'b00, EMAX}))      res = {sg4, EMAX, {FRAC_W{1'b0}}};
    else                                        res = {sg4, EXP_W'(en), frac};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= v4;
    out_res <= res;
  end
endmodule

// File: rtl/hub_fp_add_chk.sv
module hub_fp_add_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_sub,
  input logic [EXP_W+FRAC_W:0] in_a,
  input logic [EXP_W+FRAC_W:0] in_b,
  input logic                  out_valid,
  input logic [EXP_W+FRAC_W:0] out_res
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [EXP_W-1:0] EMAX = '1;
  localparam logic [FRAC_W-1:0] QFRAC = {1'b1, {(FRAC_W-1){1'b0}}};

  logic [2:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n)         age <= '0;
    else if (age != 3'd5) age <= age + 3'd1;
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3'd5) |-> (out_valid == $past(in_valid, 5)));

  assert_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((age == 3'd5) && $past(in_valid, 5) && $past(in_sub, 5) &&
     ($past(in_a, 5) == $past(in_b, 5)) &&
     ($past(in_a[W-2 -: EXP_W], 5) != '0) &&
     ($past(in_a[W-2 -: EXP_W], 5) != EMAX)) |-> (out_res == '0));

  assert_no_subnormal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_res[W-2 -: EXP_W] == '0)) |-> (out_res[FRAC_W-1:0] == '0));

  assert_special_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_res[W-2 -: EXP_W] == EMAX)) |->
      ((out_res[FRAC_W-1:0] == '0) ||
       ((out_res[FRAC_W-1:0] == QFRAC) && !out_res[W-1])));
endmodule

bind hub_fp_add hub_fp_add_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sub(in_sub),
  .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_res(out_res)
);

// File: tb/hub_fp_add_tb.sv
module hub_fp_add_tb;
  localparam int CLK_P = 10;
  localparam int LAT   = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sub = 1'b0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic [31:0] out_res;

  hub_fp_add u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sub(in_sub),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_res(out_res)
  );

  always #(CLK_P/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  int issued = 0;
  int seen   = 0;
  logic [31:0] exp_q[$];
  int          cyc_q[$];
  string       tag_q[$];

  function automatic logic [31:0] ref_add(logic [31:0] a, logic [31:0] b, logic sub);
    logic sa, sb, sg;
    int ea, eb, eh, el, d;
    longint fa, fb, mh, ml, al, r;
    sa = a[31]; sb = b[31] ^ sub;
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    fa = longint'(a[22:0]); fb = longint'(b[22:0]);
    if ((ea == 255 && fa != 0) || (eb == 255 && fb != 0)) return 32'h7FC00000;
    if (ea == 255 && eb == 255 && sa != sb) return 32'h7FC00000;
    if (ea == 255) return {sa, 31'h7F800000};
    if (eb == 255) return {sb, 31'h7F800000};
    if (ea == 0 && eb == 0) return {sa & sb, 31'b0};
    if (eb == 0) return a;
    if (ea == 0) return {sb, b[30:0]};
    if (eb > ea || (eb == ea && fb > fa)) begin
      sg = sb; eh = eb; el = ea;
      mh = (64'd1 << 24) | (fb << 1) | 64'd1;
      ml = (64'd1 << 24) | (fa << 1) | 64'd1;
    end else begin
      sg = sa; eh = ea; el = eb;
      mh = (64'd1 << 24) | (fa << 1) | 64'd1;
      ml = (64'd1 << 24) | (fb << 1) | 64'd1;
    end
    d  = eh - el;
    al = (d >= 25) ? 64'd0 : (ml >> d);
    r  = (sa != sb) ? mh - al : mh + al;
    if (r == 0) return 32'h0;
    if (r >= (64'd1 << 25)) begin r = r >> 1; eh++; end
    while (r < (64'd1 << 24)) begin r = r << 1; eh--; end
    if (eh < 1) return {sg, 31'b0};
    if (eh >= 255) return {sg, 31'h7F800000};
    return {sg, 8'(eh), 23'(r >> 1)};
  endfunction

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic sub,
                       input logic [31:0] expv, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_sub = sub; in_a = a; in_b = b;
    exp_q.push_back(expv);
    cyc_q.push_back(cyc);
    tag_q.push_back(tag);
    issued++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_a = $urandom; in_b = $urandom; in_sub = 1'b1;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      seen++;
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R3 unexpected result: actual out_valid=1 res=%h expected out_valid=0", out_res);
      end else begin
        logic [31:0] e;
        int c;
        string t;
        e = exp_q.pop_front(); c = cyc_q.pop_front(); t = tag_q.pop_front();
        checks++;
        if (out_res !== e) begin
          fails++;
          $display("FAIL %s result: actual=%h expected=%h", t, out_res, e);
        end
        checks++;
        if (cyc - c != LAT) begin
          fails++;
          $display("FAIL R2 latency: actual=%0d expected=%0d", cyc - c, LAT);
        end
      end
    end
  end

  bit done = 1'b0;

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R12: operations presented in reset are dropped
    repeat (2) @(negedge clk);
    in_valid = 1'b1; in_a = 32'h3F800000; in_b = 32'h3F800000;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R12 reset: actual out_valid=%b expected=0", out_valid);
    end
    in_valid = 1'b0;
    rst_n = 1'b1;
    idle(8);
    checks++;
    if (seen != 0) begin
      fails++; $display("FAIL R12 dropped op: actual results=%0d expected=0", seen);
    end

    // directed, back to back
    issue(32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, "R1");
    issue(32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, "R7");
    issue(32'hBF800000, 32'h3F800000, 1'b0, 32'h00000000, "R7");
    issue(32'hC1234567, 32'hC1234567, 1'b1, 32'h00000000, "R7");
    issue(32'h3F800000, 32'h40000000, 1'b1, 32'hBF800001, "R4");
    issue(32'h4C000000, 32'h3F800000, 1'b0, 32'h4C000000, "R6");
    issue(32'h3F800000, 32'h4C000000, 1'b1, 32'hCC000000, "R6");
    issue(32'h00000000, 32'h40400000, 1'b0, 32'h40400000, "R8");
    issue(32'h00000000, 32'h40400000, 1'b1, 32'hC0400000, "R8");
    issue(32'h00000123, 32'h40400000, 1'b0, 32'h40400000, "R8");
    issue(32'h80000000, 32'h80000000, 1'b0, 32'h80000000, "R8");
    issue(32'h00800001, 32'h00800000, 1'b1, 32'h00000000, "R9");
    issue(32'h80800001, 32'h80800000, 1'b1, 32'h80000000, "R9");
    issue(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, "R10");
    issue(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 32'hFF800000, "R10");
    issue(32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000, "R11");
    issue(32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, "R11");
    issue(32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, "R11");
    issue(32'h7F800001, 32'h00000000, 1'b0, 32'h7FC00000, "R11");
    idle(3);

    // R5: random operands with close exponents, back to back and with gaps
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a, b;
      logic s;
      int ea, eb;
      ea = 100 + int'($urandom % 40);
      eb = (k % 3 == 0) ? 100 + int'($urandom % 40) : ea + int'($urandom % 5) - 2;
      a = {1'($urandom), 8'(ea), 23'($urandom)};
      b = {1'($urandom), 8'(eb), 23'($urandom)};
      if (k % 7 == 0) b[22:4] = a[22:4];
      s = 1'($urandom);
      issue(a, b, s, ref_add(a, b, s), "R5");
      if (k % 50 == 49) idle(1 + k % 4);
    end
    idle(LAT + 4);

    // R3: exactly one result per accepted operation
    checks++;
    if (seen != issued || exp_q.size() != 0) begin
      fails++;
      $display("FAIL R3 result count: actual=%0d expected=%0d", seen, issued);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule